// File: doc/BRIEF.md
# GPE and Slot-Hotplug Register Block

This block holds a general-purpose event (GPE) status/enable pair and the slot-hotplug bookkeeping that goes with it. Software reaches every register one byte at a time over a simple register bus. A read returns its data one cycle later, marked by a valid flag. The 16-bit status and enable registers each occupy two byte addresses, low byte at the even address. The 32-slot inserted and removed bitmaps occupy four byte addresses each, least significant byte first.

Platform logic reports hotplug activity on two event inputs that share a 5-bit slot number. Each accepted event wipes both bitmaps and then records its own slot in one of them. It also raises the hotplug bit of the GPE status register and fires a one-clock interrupt pulse. Software asks for a slot to be ejected by writing a bit mask to the eject window. The block converts the lowest set bit of that mask into a slot number and presents it with a one-clock strobe. Two small state machines set the pulse timing. The hotplug notifier has states HP_IDLE and HP_NOTIFY: an accepted event moves it to HP_NOTIFY, and a cycle without an event returns it to HP_IDLE. The eject sequencer has states EJ_IDLE and EJ_FIRE: a nonzero eject write moves it to EJ_FIRE, and a cycle without such a write returns it to EJ_IDLE.

Top module: `gpe_hotplug_regs`

## Requirements
- R1: After reset every register reads 0x00, and `rd_valid`, `irq_pulse` and `ej_strobe` are low.
- R2: Address 0x00 holds status bits 7..0 and 0x01 holds status bits 15..8. A write clears each bit of the addressed byte that is written as 1. Bits written as 0 and the other byte keep their value.
- R3: Address 0x02 holds enable bits 7..0 and 0x03 holds enable bits 15..8. A write replaces the addressed byte and leaves the other byte unchanged.
- R4: An insert event clears both bitmaps and then sets the inserted-bitmap bit selected by `evt_slot`. The removed bitmap reads all zero afterwards.
- R5: A remove event on its own clears both bitmaps and then sets the removed-bitmap bit selected by `evt_slot`. The inserted bitmap reads all zero afterwards.
- R6: Every accepted hotplug event sets status bit 1. If a clearing write to that bit falls in the same cycle, the event wins.
- R7: `irq_pulse` is high in the cycle after each cycle with an accepted event and low otherwise. Events in consecutive cycles keep it high for consecutive cycles.
- R8: If insert and remove are asserted together, only the insert is recorded.
- R9: A byte write to eject address 0x18+k with a nonzero value asserts `ej_strobe` for one cycle, starting in the next cycle. `ej_slot` then equals 8*k plus the index of the lowest set bit of the byte.
- R10: An eject write of 0x00 produces no strobe.
- R11: The eject addresses 0x18..0x1B read 0x00. Any address outside the GPE, bitmap and eject windows reads 0xFF.
- R12: A read asserted in one cycle gives `rd_valid` high in the next cycle, with that address's byte on `rd_data`. The inserted bitmap occupies 0x10..0x13 and the removed bitmap 0x14..0x17, with slots 8k..8k+7 in byte k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 6 | Byte address |
| bus_wr | input | 1 | Byte write request |
| bus_rd | input | 1 | Byte read request |
| bus_wdata | input | 8 | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after bus_rd |
| rd_data | output | 8 | Read data |
| ins_evt | input | 1 | Slot insert event |
| rem_evt | input | 1 | Slot remove event |
| evt_slot | input | 5 | Slot number of the event |
| irq_pulse | output | 1 | One-clock interrupt pulse per event |
| ej_strobe | output | 1 | One-clock eject request |
| ej_slot | output | 5 | Slot to eject, valid with ej_strobe |

## Verification
The hardest case to reach from the ports is a byte-clearing status write that lands in the same clock as a hotplug event. The outcome depends on set-over-clear ordering inside the status lane. The bench drives `bus_wr` to address 0x00 and `ins_evt` on the same negative edge, then reads the status byte back. It also presents events on two adjacent cycles, so the notifier must stay in HP_NOTIFY and hold the interrupt high without a gap. The wipe-then-set rule for the bitmaps is shown with two kinds of event pairs: events that select slots in different bytes, and an insert followed by a remove.

// File: rtl/gpe_hp_pkg.sv
package gpe_hp_pkg;

    typedef enum logic [0:0] {
        HP_IDLE   = 1'b0,
        HP_NOTIFY = 1'b1
    } hp_state_e;

    typedef enum logic [0:0] {
        EJ_IDLE = 1'b0,
        EJ_FIRE = 1'b1
    } ej_state_e;

    // index of the lowest set bit in a byte (0 when the byte is zero)
    function automatic logic [2:0] low_bit8(input logic [7:0] v);
        logic [2:0] r;
        r = 3'd0;
        for (int i = 7; i >= 0; i--) begin
            if (v[i]) r = 3'(i);
        end
        return r;
    endfunction

endpackage

// File: rtl/gpe_event_regs.sv
module gpe_event_regs #(
    parameter int GPE_W      = 16,
    parameter int HP_STS_BIT = 1,
    localparam int GPE_BYTES = GPE_W / 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [GPE_BYTES-1:0] sts_wr_lane,
    input  logic [GPE_BYTES-1:0] en_wr_lane,
    input  logic [7:0]           wdata,
    input  logic                 hp_set,
    output logic [GPE_W-1:0]     sts_q,
    output logic [GPE_W-1:0]     en_q
);
    localparam logic [GPE_W-1:0] HP_MASK = GPE_W'(1) << HP_STS_BIT;

    for (genvar g = 0; g < GPE_BYTES; g++) begin : g_lane
        logic [7:0] sts_b;
        logic [7:0] en_b;
        logic [7:0] clr_b;
        logic [7:0] set_b;

        always_comb begin
            clr_b = sts_wr_lane[g] ? wdata : 8'h00;
            set_b = hp_set ? HP_MASK[g*8 +: 8] : 8'h00;
        end

        // set wins over a same-cycle clear
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sts_b <= 8'h00;
                en_b  <= 8'h00;
            end else begin
                sts_b <= (sts_b & ~clr_b) | set_b;
                if (en_wr_lane[g]) en_b <= wdata;
            end
        end

        assign sts_q[g*8 +: 8] = sts_b;
        assign en_q[g*8 +: 8]  = en_b;
    end

endmodule

// File: rtl/hp_slot_tracker.sv
module hp_slot_tracker
    import gpe_hp_pkg::*;
#(
    parameter int SLOTS = 32,
    localparam int SLOT_W = $clog2(SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ins_evt,
    input  logic              rem_evt,
    input  logic [SLOT_W-1:0] evt_slot,
    output logic              accepted,
    output logic [SLOTS-1:0]  ins_map,
    output logic [SLOTS-1:0]  rem_map,
    output logic              irq_pulse
);
    hp_state_e        state_q;
    hp_state_e        state_d;
    logic [SLOTS-1:0] slot_bit;

    assign accepted = ins_evt | rem_evt;
    assign slot_bit = SLOTS'(1) << evt_slot;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            HP_IDLE:   state_d = accepted ? HP_NOTIFY : HP_IDLE;
            HP_NOTIFY: state_d = accepted ? HP_NOTIFY : HP_IDLE;
            default:   state_d = HP_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= HP_IDLE;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        irq_pulse = 1'b0;
        unique case (state_q)
            HP_IDLE:   irq_pulse = 1'b0;
            HP_NOTIFY: irq_pulse = 1'b1;
            default:   irq_pulse = 1'b0;
        endcase
    end

    // bitmaps: wipe both, then mark one; insert takes priority
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ins_map <= '0;
            rem_map <= '0;
        end else if (accepted) begin
            ins_map <= ins_evt ? slot_bit : '0;
            rem_map <= ins_evt ? '0 : slot_bit;
        end
    end

endmodule

// File: rtl/eject_decoder.sv
module eject_decoder
    import gpe_hp_pkg::*;
#(
    parameter int SLOTS = 32,
    localparam int SLOT_W    = $clog2(SLOTS),
    localparam int MAP_BYTES = SLOTS / 8,
    localparam int LANE_W    = (MAP_BYTES > 1) ? $clog2(MAP_BYTES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [LANE_W-1:0] lane,
    input  logic [7:0]        wdata,
    output logic              ej_strobe,
    output logic [SLOT_W-1:0] ej_slot
);
    ej_state_e         state_q;
    ej_state_e         state_d;
    logic              fire;
    logic [SLOT_W-1:0] slot_calc;

    assign fire      = wr_en && (wdata != 8'h00);
    assign slot_calc = SLOT_W'({lane, low_bit8(wdata)});

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            EJ_IDLE: state_d = fire ? EJ_FIRE : EJ_IDLE;
            EJ_FIRE: state_d = fire ? EJ_FIRE : EJ_IDLE;
            default: state_d = EJ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= EJ_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)    ej_slot <= '0;
        else if (fire) ej_slot <= slot_calc;
    end

    always_comb begin
        ej_strobe = 1'b0;
        unique case (state_q)
            EJ_IDLE: ej_strobe = 1'b0;
            EJ_FIRE: ej_strobe = 1'b1;
            default: ej_strobe = 1'b0;
        endcase
    end

endmodule

// File: rtl/gpe_hotplug_regs.sv
module gpe_hotplug_regs #(
    parameter int ADDR_W     = 6,
    parameter int GPE_W      = 16,
    parameter int SLOTS      = 32,
    parameter int HP_STS_BIT = 1,
    parameter int GPE_BASE   = 0,
    parameter int HP_BASE    = 16,
    parameter int EJ_BASE    = 24,
    localparam int SLOT_W    = $clog2(SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [7:0]        bus_wdata,
    output logic              rd_valid,
    output logic [7:0]        rd_data,
    input  logic              ins_evt,
    input  logic              rem_evt,
    input  logic [SLOT_W-1:0] evt_slot,
    output logic              irq_pulse,
    output logic              ej_strobe,
    output logic [SLOT_W-1:0] ej_slot
);
    localparam int GPE_BYTES = GPE_W / 8;
    localparam int MAP_BYTES = SLOTS / 8;
    localparam int LANE_W    = (MAP_BYTES > 1) ? $clog2(MAP_BYTES) : 1;

    localparam logic [ADDR_W-1:0] GPE_LO  = ADDR_W'(GPE_BASE);
    localparam logic [ADDR_W-1:0] HP_LO   = ADDR_W'(HP_BASE);
    localparam logic [ADDR_W-1:0] EJ_LO   = ADDR_W'(EJ_BASE);
    localparam logic [ADDR_W-1:0] GPE_SPAN = ADDR_W'(2 * GPE_BYTES);
    localparam logic [ADDR_W-1:0] HP_SPAN  = ADDR_W'(2 * MAP_BYTES);
    localparam logic [ADDR_W-1:0] EJ_SPAN  = ADDR_W'(MAP_BYTES);

    logic [ADDR_W-1:0]    gpe_off, hp_off, ej_off;
    logic                 in_gpe, in_hp, in_ej;
    logic [GPE_BYTES-1:0] sts_wr_lane, en_wr_lane;
    logic [GPE_W-1:0]     sts_q, en_q;
    logic [SLOTS-1:0]     ins_map, rem_map;
    logic                 hp_accept;
    logic [7:0]           rd_mux;

    // address decode
    always_comb begin
        gpe_off = bus_addr - GPE_LO;
        hp_off  = bus_addr - HP_LO;
        ej_off  = bus_addr - EJ_LO;
        in_gpe  = (bus_addr >= GPE_LO) && (gpe_off < GPE_SPAN);
        in_hp   = (bus_addr >= HP_LO)  && (hp_off  < HP_SPAN);
        in_ej   = (bus_addr >= EJ_LO)  && (ej_off  < EJ_SPAN);
    end

    for (genvar g = 0; g < GPE_BYTES; g++) begin : g_wr_lane
        assign sts_wr_lane[g] = bus_wr && in_gpe && (gpe_off == ADDR_W'(g));
        assign en_wr_lane[g]  = bus_wr && in_gpe && (gpe_off == ADDR_W'(GPE_BYTES + g));
    end

    gpe_event_regs #(
        .GPE_W      (GPE_W),
        .HP_STS_BIT (HP_STS_BIT)
    ) u_gpe (
        .clk         (clk),
        .rst_n       (rst_n),
        .sts_wr_lane (sts_wr_lane),
        .en_wr_lane  (en_wr_lane),
        .wdata       (bus_wdata),
        .hp_set      (hp_accept),
        .sts_q       (sts_q),
        .en_q        (en_q)
    );

    hp_slot_tracker #(
        .SLOTS (SLOTS)
    ) u_hp (
        .clk       (clk),
        .rst_n     (rst_n),
        .ins_evt   (ins_evt),
        .rem_evt   (rem_evt),
        .evt_slot  (evt_slot),
        .accepted  (hp_accept),
        .ins_map   (ins_map),
        .rem_map   (rem_map),
        .irq_pulse (irq_pulse)
    );

    eject_decoder #(
        .SLOTS (SLOTS)
    ) u_ej (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (bus_wr && in_ej),
        .lane      (ej_off[LANE_W-1:0]),
        .wdata     (bus_wdata),
        .ej_strobe (ej_strobe),
        .ej_slot   (ej_slot)
    );

    // read multiplexer
    always_comb begin
        rd_mux = 8'hFF;
        if (in_gpe) begin
            for (int k = 0; k < GPE_BYTES; k++) begin
                if (gpe_off == ADDR_W'(k))             rd_mux = sts_q[k*8 +: 8];
                if (gpe_off == ADDR_W'(GPE_BYTES + k)) rd_mux = en_q[k*8 +: 8];
            end
        end else if (in_hp) begin
            for (int k = 0; k < MAP_BYTES; k++) begin
                if (hp_off == ADDR_W'(k))             rd_mux = ins_map[k*8 +: 8];
                if (hp_off == ADDR_W'(MAP_BYTES + k)) rd_mux = rem_map[k*8 +: 8];
            end
        end else if (in_ej) begin
            rd_mux = 8'h00;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= 8'h00;
        end else begin
            rd_valid <= bus_rd;
            if (bus_rd) rd_data <= rd_mux;
        end
    end

endmodule

// File: rtl/gpe_hp_checker.sv
module gpe_hp_checker #(
    parameter int ADDR_W     = 6,
    parameter int GPE_W      = 16,
    parameter int SLOTS      = 32,
    parameter int HP_STS_BIT = 1,
    parameter int EJ_BASE    = 24,
    localparam int SLOT_W    = $clog2(SLOTS)
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [7:0]        bus_wdata,
    input logic              rd_valid,
    input logic              ins_evt,
    input logic              rem_evt,
    input logic              irq_pulse,
    input logic              ej_strobe,
    input logic [GPE_W-1:0]  sts_q,
    input logic [SLOTS-1:0]  ins_map,
    input logic [SLOTS-1:0]  rem_map
);
    localparam logic [ADDR_W-1:0] EJ_LO = ADDR_W'(EJ_BASE);
    localparam logic [ADDR_W-1:0] EJ_HI = ADDR_W'(EJ_BASE + SLOTS / 8);

    logic ej_hit;
    assign ej_hit = (bus_addr >= EJ_LO) && (bus_addr < EJ_HI);

    p_irq_follows_event_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_evt || rem_evt) |=> irq_pulse);

    p_irq_has_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |-> $past(ins_evt || rem_evt));

    p_event_sets_status_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_evt || rem_evt) |=> sts_q[HP_STS_BIT]);

    p_insert_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ins_evt |=> ($countones(ins_map) == 1 && rem_map == '0));

    p_remove_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rem_evt && !ins_evt) |=> ($countones(rem_map) == 1 && ins_map == '0));

    p_strobe_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ej_strobe |-> $past(bus_wr && ej_hit && bus_wdata != 8'h00));

    p_rd_valid_rise_r12: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |=> rd_valid);

    p_rd_valid_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> !rd_valid);

endmodule

bind gpe_hotplug_regs gpe_hp_checker #(
    .ADDR_W     (ADDR_W),
    .GPE_W      (GPE_W),
    .SLOTS      (SLOTS),
    .HP_STS_BIT (HP_STS_BIT),
    .EJ_BASE    (EJ_BASE)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .rd_valid  (rd_valid),
    .ins_evt   (ins_evt),
    .rem_evt   (rem_evt),
    .irq_pulse (irq_pulse),
    .ej_strobe (ej_strobe),
    .sts_q     (sts_q),
    .ins_map   (ins_map),
    .rem_map   (rem_map)
);

// File: tb/gpe_hotplug_regs_tb.sv
module gpe_hotplug_regs_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic       rd_valid;
    logic [7:0] rd_data;
    logic       ins_evt = 1'b0;
    logic       rem_evt = 1'b0;
    logic [4:0] evt_slot = '0;
    logic       irq_pulse;
    logic       ej_strobe;
    logic [4:0] ej_slot;

    int    vectors = 0;
    int    miscompares = 0;
    bit    done = 1'b0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #5 clk = ~clk;

    gpe_hotplug_regs u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .rd_valid(rd_valid),
        .rd_data(rd_data), .ins_evt(ins_evt), .rem_evt(rem_evt),
        .evt_slot(evt_slot), .irq_pulse(irq_pulse), .ej_strobe(ej_strobe),
        .ej_slot(ej_slot)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor: pops expected read bytes as rd_valid appears
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (exp_q.size() == 0) begin
                check("R12 unexpected rd_valid", 1, 0);
            end else begin
                check(tag_q.pop_front(), {24'h0, rd_data}, {24'h0, exp_q.pop_front()});
            end
        end
    end

    task automatic bus_read(input logic [5:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic bus_write(input logic [5:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic hp_event(input logic ins, input logic rem, input logic [4:0] s);
        @(negedge clk);
        ins_evt = ins; rem_evt = rem; evt_slot = s;
        @(negedge clk);
        ins_evt = 1'b0; rem_evt = 1'b0;
        check("R7 irq high after event", irq_pulse, 1);
        @(negedge clk);
        check("R7 irq one cycle", irq_pulse, 0);
    endtask

    task automatic ej_write(input logic [5:0] a, input logic [7:0] d,
                            input logic fire, input logic [4:0] s, input string tag);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        check(tag, ej_strobe, fire);
        if (fire) check(tag, ej_slot, s);
        @(negedge clk);
        check(tag, ej_strobe, 0);
    endtask

    task automatic read_maps(input logic [31:0] ins_exp, input logic [31:0] rem_exp, input string tag);
        for (int k = 0; k < 4; k++) begin
            bus_read(6'(16 + k), ins_exp[k*8 +: 8], tag);
            bus_read(6'(20 + k), rem_exp[k*8 +: 8], tag);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 rd_valid reset", rd_valid, 0);
        check("R1 irq reset", irq_pulse, 0);
        check("R1 strobe reset", ej_strobe, 0);
        for (int a = 0; a < 4; a++) bus_read(6'(a), 8'h00, "R1 gpe reset");
        read_maps(32'h0, 32'h0, "R1 map reset");

        // R3 enable byte writes
        bus_write(6'h02, 8'hA5);
        bus_read(6'h02, 8'hA5, "R3 en lo");
        bus_read(6'h03, 8'h00, "R3 en hi kept");
        bus_write(6'h03, 8'h3C);
        bus_read(6'h02, 8'hA5, "R3 en lo kept");
        bus_read(6'h03, 8'h3C, "R3 en hi");
        bus_write(6'h02, 8'h0F);
        bus_read(6'h02, 8'h0F, "R3 en lo replaced");
        bus_read(6'h03, 8'h3C, "R3 en hi kept");

        // R4 / R6 insert
        hp_event(1'b1, 1'b0, 5'd5);
        read_maps(32'h0000_0020, 32'h0, "R4 insert slot5");
        bus_read(6'h00, 8'h02, "R6 status bit1");

        // R2 W1C per byte
        bus_write(6'h01, 8'hFF);
        bus_read(6'h00, 8'h02, "R2 high write keeps low");
        bus_write(6'h00, 8'hFD);
        bus_read(6'h00, 8'h02, "R2 zero bit kept");
        bus_write(6'h00, 8'h02);
        bus_read(6'h00, 8'h00, "R2 bit cleared");
        bus_read(6'h02, 8'h0F, "R2 enable untouched");

        hp_event(1'b1, 1'b0, 5'd31);
        read_maps(32'h8000_0000, 32'h0, "R4 wipe then set slot31");

        // R5 remove
        hp_event(1'b0, 1'b1, 5'd12);
        read_maps(32'h0, 32'h0000_1000, "R5 remove slot12");

        // R8 simultaneous
        hp_event(1'b1, 1'b1, 5'd9);
        read_maps(32'h0000_0200, 32'h0, "R8 insert priority");

        // R7 back-to-back events
        @(negedge clk);
        ins_evt = 1'b1; evt_slot = 5'd0;
        @(negedge clk);
        ins_evt = 1'b0; rem_evt = 1'b1; evt_slot = 5'd1;
        check("R7 irq first", irq_pulse, 1);
        @(negedge clk);
        rem_evt = 1'b0;
        check("R7 irq second", irq_pulse, 1);
        @(negedge clk);
        check("R7 irq drop", irq_pulse, 0);
        read_maps(32'h0, 32'h0000_0002, "R7 last event kept");

        // R6 same-cycle clear versus event
        bus_write(6'h00, 8'h02);
        bus_read(6'h00, 8'h00, "R6 pre-clear");
        @(negedge clk);
        bus_addr = 6'h00; bus_wdata = 8'h02; bus_wr = 1'b1;
        ins_evt = 1'b1; evt_slot = 5'd3;
        @(negedge clk);
        bus_wr = 1'b0; ins_evt = 1'b0;
        bus_read(6'h00, 8'h02, "R6 set beats clear");

        // R9 / R10 eject
        ej_write(6'h18, 8'h0C, 1'b1, 5'd2,  "R9 eject lane0");
        ej_write(6'h1B, 8'h80, 1'b1, 5'd31, "R9 eject lane3");
        ej_write(6'h19, 8'h01, 1'b1, 5'd8,  "R9 eject lane1");
        ej_write(6'h1A, 8'h00, 1'b0, 5'd0,  "R10 eject zero");

        // R11 read-only eject and unused space
        for (int a = 24; a < 28; a++) bus_read(6'(a), 8'h00, "R11 eject reads zero");
        bus_read(6'h04, 8'hFF, "R11 unused");
        bus_read(6'h0F, 8'hFF, "R11 unused");
        bus_read(6'h1C, 8'hFF, "R11 unused");
        bus_read(6'h3F, 8'hFF, "R11 unused");

        repeat (3) @(negedge clk);
        check("R12 all reads returned", exp_q.size(), 0);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            vectors++;
            miscompares++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule